// File: doc/BRIEF.md
# Ping-Pong Working Memory Controller

This block owns a working store made of two equal banks placed between a transfer (DMA) engine and a compute engine. At any moment one bank belongs to the DMA side and the other to the compute side. Each side reaches only its own bank through its port, so neither side can disturb the other's data.

During one period the DMA side drains the results that compute left in its bank and fills the same bank with fresh operands. Meanwhile compute works on the other bank. Each side raises a one-cycle done strobe when it finishes. The banks change hands only once both sides have finished, which lets external memory traffic overlap with computation.

Each side's completion is held in a sticky flag until the swap. Both flags clear in the cycle the swap happens. Reads return data one cycle after they are issued. Writes take effect in the cycle they are issued.

Top module: `pp_workmem`

## Requirements
- R1: After reset `dma_bank` is 0: the DMA port reaches bank 0 and the compute port reaches bank 1.
- R2: A read issued on either port returns on its `rdata` the word stored at that address in the bank that port owned in the issuing cycle, valid in the following cycle.
- R3: Within one period the DMA port can read results from its bank and write new operands into that same bank; a later read in the same period returns the new word.
- R4: A write on one port never changes the word at the same address in the bank owned by the other port.
- R5: A done strobe from one side alone never swaps the banks. It is remembered, so the swap happens on the clock edge where the other side's strobe arrives, however many cycles later.
- R6: When both sides' done strobes arrive in the same cycle, `dma_bank` inverts on that clock edge.
- R7: Both remembered completions clear at the swap. After a swap a single side's strobe does not swap again, and a strobe that arrives during the swap cycle is not carried into the next period.
- R8: After a swap each port reaches the bank the other port owned before, so results written by compute become readable on the DMA port at the same address, and DMA operands become readable on the compute port.
- R9: Accesses issued in the swap cycle use the old ownership. This covers a read whose data returns after the swap and a write issued in that cycle.
- R10: Repeated strobes from one side before the other finishes cause only one swap.
- R11: The full address range, 0 through 2^AW-1, is usable on each bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_en | input | 1 | DMA access request |
| dma_we | input | 1 | DMA write (1) or read (0) |
| dma_addr | input | AW | DMA word address |
| dma_wdata | input | DW | DMA write data |
| dma_rdata | output | DW | DMA read data, one cycle after the request |
| dma_done | input | 1 | DMA side finished its period (strobe) |
| cmp_en | input | 1 | Compute access request |
| cmp_we | input | 1 | Compute write (1) or read (0) |
| cmp_addr | input | AW | Compute word address |
| cmp_wdata | input | DW | Compute write data |
| cmp_rdata | output | DW | Compute read data, one cycle after the request |
| cmp_done | input | 1 | Compute side finished its period (strobe) |
| dma_bank | output | 1 | Bank currently owned by the DMA side; compute owns the other |

## Verification
The done strobes are driven in four patterns: one side alone, both sides together, repeated strobes from one side, and a lone strobe just after a swap. Together these separate sticky completion from level-sensitive completion and show that the flags really clear at the swap. Writes go to the same address on both ports, which shows bank isolation. A read, a write and both strobes are issued in a single cycle to show that the access follows the old ownership while the read data returns after the swap. Address 0 and the top address are both exercised.

// File: rtl/pp_workmem_pkg.sv
package pp_workmem_pkg;
  typedef logic bank_id_t;

  function automatic bank_id_t other_bank(input bank_id_t b);
    return ~b;
  endfunction
endpackage

// File: rtl/pp_bank_ram.sv
module pp_bank_ram #(
  parameter int DW = 32,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/pp_swap_ctrl.sv
module pp_swap_ctrl
  import pp_workmem_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     dma_done,
  input  logic     cmp_done,
  output bank_id_t sel,
  output bank_id_t sel_q
);
  logic dma_flag, cmp_flag;
  logic dma_fin, cmp_fin, swap;

  assign dma_fin = dma_flag | dma_done;
  assign cmp_fin = cmp_flag | cmp_done;
  assign swap    = dma_fin & cmp_fin;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel      <= 1'b0;
      dma_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else if (swap) begin
      sel      <= other_bank(sel);
      dma_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      dma_flag <= dma_fin;
      cmp_flag <= cmp_fin;
    end
  end

  // ownership seen by the read issued in the previous cycle
  always_ff @(posedge clk) begin
    if (rst) sel_q <= 1'b0;
    else     sel_q <= sel;
  end
endmodule

// File: rtl/pp_port_steer.sv
module pp_port_steer
  import pp_workmem_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 10
) (
  input  bank_id_t      sel,
  input  logic          dma_en,
  input  logic          dma_we,
  input  logic [AW-1:0] dma_addr,
  input  logic [DW-1:0] dma_wdata,
  input  logic          cmp_en,
  input  logic          cmp_we,
  input  logic [AW-1:0] cmp_addr,
  input  logic [DW-1:0] cmp_wdata,
  output logic          bk_en    [2],
  output logic          bk_we    [2],
  output logic [AW-1:0] bk_addr  [2],
  output logic [DW-1:0] bk_wdata [2]
);
  for (genvar i = 0; i < 2; i++) begin : g_bank
    logic dma_owns;
    assign dma_owns    = (sel == bank_id_t'(i));
    assign bk_en[i]    = dma_owns ? dma_en    : cmp_en;
    assign bk_we[i]    = dma_owns ? dma_we    : cmp_we;
    assign bk_addr[i]  = dma_owns ? dma_addr  : cmp_addr;
    assign bk_wdata[i] = dma_owns ? dma_wdata : cmp_wdata;
  end
endmodule

// File: rtl/pp_workmem.sv
module pp_workmem
  import pp_workmem_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dma_en,
  input  logic          dma_we,
  input  logic [AW-1:0] dma_addr,
  input  logic [DW-1:0] dma_wdata,
  output logic [DW-1:0] dma_rdata,
  input  logic          dma_done,
  input  logic          cmp_en,
  input  logic          cmp_we,
  input  logic [AW-1:0] cmp_addr,
  input  logic [DW-1:0] cmp_wdata,
  output logic [DW-1:0] cmp_rdata,
  input  logic          cmp_done,
  output logic          dma_bank
);
  bank_id_t      sel, sel_q;
  logic          bk_en    [2];
  logic          bk_we    [2];
  logic [AW-1:0] bk_addr  [2];
  logic [DW-1:0] bk_wdata [2];
  logic [DW-1:0] bk_rdata [2];

  pp_swap_ctrl u_ctrl (
    .clk(clk), .rst(rst), .dma_done(dma_done), .cmp_done(cmp_done),
    .sel(sel), .sel_q(sel_q)
  );

  pp_port_steer #(.DW(DW), .AW(AW)) u_steer (
    .sel(sel),
    .dma_en(dma_en), .dma_we(dma_we), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
    .cmp_en(cmp_en), .cmp_we(cmp_we), .cmp_addr(cmp_addr), .cmp_wdata(cmp_wdata),
    .bk_en(bk_en), .bk_we(bk_we), .bk_addr(bk_addr), .bk_wdata(bk_wdata)
  );

  for (genvar i = 0; i < 2; i++) begin : g_ram
    pp_bank_ram #(.DW(DW), .AW(AW)) u_ram (
      .clk(clk), .en(bk_en[i]), .we(bk_we[i]), .addr(bk_addr[i]),
      .wdata(bk_wdata[i]), .rdata(bk_rdata[i])
    );
  end

  assign dma_rdata = bk_rdata[sel_q];
  assign cmp_rdata = bk_rdata[other_bank(sel_q)];
  assign dma_bank  = sel;
endmodule

// File: rtl/pp_workmem_chk.sv
module pp_workmem_chk #(
  parameter int DW = 32,
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          dma_en,
  input logic          dma_we,
  input logic [AW-1:0] dma_addr,
  input logic [DW-1:0] dma_wdata,
  input logic [DW-1:0] dma_rdata,
  input logic          dma_done,
  input logic          cmp_en,
  input logic          cmp_we,
  input logic [AW-1:0] cmp_addr,
  input logic [DW-1:0] cmp_wdata,
  input logic [DW-1:0] cmp_rdata,
  input logic          cmp_done,
  input logic          dma_bank
);
  logic seen_d, seen_c, both;
  assign both = (seen_d | dma_done) & (seen_c | cmp_done);

  always_ff @(posedge clk) begin
    if (rst || both) begin
      seen_d <= 1'b0;
      seen_c <= 1'b0;
    end else begin
      seen_d <= seen_d | dma_done;
      seen_c <= seen_c | cmp_done;
    end
  end

  a_r1_reset_bank: assert property (@(posedge clk) rst |=> dma_bank == 1'b0);

  a_r5_hold_until_both: assert property (@(posedge clk) disable iff (rst)
    !both |=> $stable(dma_bank));

  a_r6_swap_when_both: assert property (@(posedge clk) disable iff (rst)
    both |=> dma_bank != $past(dma_bank));

  a_r2_dma_readback: assert property (@(posedge clk) disable iff (rst)
    (dma_en && dma_we) ##1 (dma_en && !dma_we && dma_addr == $past(dma_addr) && $stable(dma_bank))
    |=> dma_rdata == $past(dma_wdata, 2));

  a_r2_cmp_readback: assert property (@(posedge clk) disable iff (rst)
    (cmp_en && cmp_we) ##1 (cmp_en && !cmp_we && cmp_addr == $past(cmp_addr) && $stable(dma_bank))
    |=> cmp_rdata == $past(cmp_wdata, 2));
endmodule

bind pp_workmem pp_workmem_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst),
  .dma_en(dma_en), .dma_we(dma_we), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
  .dma_rdata(dma_rdata), .dma_done(dma_done),
  .cmp_en(cmp_en), .cmp_we(cmp_we), .cmp_addr(cmp_addr), .cmp_wdata(cmp_wdata),
  .cmp_rdata(cmp_rdata), .cmp_done(cmp_done), .dma_bank(dma_bank)
);

// File: tb/tb_pp_workmem.sv
module tb_pp_workmem;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 10;
  localparam int NV = 8;
  // vector: side(1=compute) | we | addr | data (write data, or expected read data)
  localparam logic [43:0] VEC [NV] = '{
    {1'b0, 1'b1, 10'd5,    32'hA000_0005},
    {1'b1, 1'b1, 10'd5,    32'hB000_0005},
    {1'b0, 1'b0, 10'd5,    32'hA000_0005},
    {1'b1, 1'b0, 10'd5,    32'hB000_0005},
    {1'b0, 1'b1, 10'd1023, 32'hC000_03FF},
    {1'b0, 1'b0, 10'd1023, 32'hC000_03FF},
    {1'b1, 1'b1, 10'd0,    32'hD000_0000},
    {1'b1, 1'b0, 10'd0,    32'hD000_0000}
  };

  logic clk = 0, rst = 1;
  logic dma_en = 0, dma_we = 0, dma_done = 0;
  logic cmp_en = 0, cmp_we = 0, cmp_done = 0;
  logic [AW-1:0] dma_addr = '0, cmp_addr = '0;
  logic [DW-1:0] dma_wdata = '0, cmp_wdata = '0;
  logic [DW-1:0] dma_rdata, cmp_rdata;
  logic dma_bank;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pp_workmem #(.DW(DW), .AW(AW)) dut (
    .clk(clk), .rst(rst),
    .dma_en(dma_en), .dma_we(dma_we), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
    .dma_rdata(dma_rdata), .dma_done(dma_done),
    .cmp_en(cmp_en), .cmp_we(cmp_we), .cmp_addr(cmp_addr), .cmp_wdata(cmp_wdata),
    .cmp_rdata(cmp_rdata), .cmp_done(cmp_done), .dma_bank(dma_bank)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic side, input logic we, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input string req);
    @(negedge clk);
    if (side) begin cmp_en = 1; cmp_we = we; cmp_addr = a; cmp_wdata = d; end
    else      begin dma_en = 1; dma_we = we; dma_addr = a; dma_wdata = d; end
    @(negedge clk);
    dma_en = 0; cmp_en = 0; dma_we = 0; cmp_we = 0;
    if (!we) check(req, side ? cmp_rdata : dma_rdata, d);
  endtask

  task automatic strobe(input logic d, input logic c);
    @(negedge clk);
    dma_done = d; cmp_done = c;
    @(negedge clk);
    dma_done = 0; cmp_done = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 reset bank", {31'd0, dma_bank}, 32'd0);

    // R2 R4 R11: vector walk in the first period
    for (int i = 0; i < NV; i++)
      access(VEC[i][43], VEC[i][42], VEC[i][41:32], VEC[i][31:0], "R2/R4/R11 vector");

    // R5: lone DMA completion is remembered
    strobe(1, 0);
    idle(3);
    check("R5 no swap on one side", {31'd0, dma_bank}, 32'd0);
    strobe(0, 1);
    check("R5 swap after late partner", {31'd0, dma_bank}, 32'd1);

    // R8: ownership handed over
    access(0, 0, 10'd5, 32'hB000_0005, "R8 dma sees compute result");
    access(1, 0, 10'd5, 32'hA000_0005, "R8 compute sees dma operand");
    // R3: DMA reads result then writes operand in the same bank period
    access(0, 0, 10'd0, 32'hD000_0000, "R3 dma drains result");
    access(0, 1, 10'd0, 32'hE000_0000, "R3 write");
    access(0, 0, 10'd0, 32'hE000_0000, "R3 dma reads new operand");

    // R6: simultaneous strobes
    strobe(1, 1);
    check("R6 simultaneous swap", {31'd0, dma_bank}, 32'd0);

    // R7: flags cleared at swap
    strobe(0, 1);
    idle(2);
    check("R7 no swap after clear", {31'd0, dma_bank}, 32'd0);
    strobe(1, 0);
    check("R7 new flag completes swap", {31'd0, dma_bank}, 32'd1);

    // R10: repeated strobes, one swap
    strobe(1, 0); strobe(1, 0); strobe(1, 0);
    check("R10 repeats alone no swap", {31'd0, dma_bank}, 32'd1);
    strobe(0, 1);
    idle(2);
    check("R10 single swap", {31'd0, dma_bank}, 32'd0);

    // R9: accesses in the swap cycle use old ownership
    access(0, 1, 10'd7, 32'hF000_0007, "R9 setup");
    access(1, 1, 10'd7, 32'h6000_0007, "R9 setup");
    @(negedge clk);
    dma_en = 1; dma_we = 0; dma_addr = 10'd7;
    cmp_en = 1; cmp_we = 1; cmp_addr = 10'd8; cmp_wdata = 32'h4000_0008;
    dma_done = 1; cmp_done = 1;
    @(negedge clk);
    dma_en = 0; cmp_en = 0; cmp_we = 0; dma_done = 0; cmp_done = 0;
    check("R9 read in swap cycle", dma_rdata, 32'hF000_0007);
    check("R6 swap with traffic", {31'd0, dma_bank}, 32'd1);
    access(0, 0, 10'd8, 32'h4000_0008, "R9 write in swap cycle old bank");
    access(0, 0, 10'd7, 32'h6000_0007, "R8 dma after swap");
    access(1, 0, 10'd7, 32'hF000_0007, "R4 compute bank untouched");

    // R7: strobe in swap cycle not carried over
    strobe(1, 1);
    strobe(0, 1);
    check("R7 swap-cycle strobe dropped", {31'd0, dma_bank}, 32'd0);

    // R1: reset mid-run
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R1 bank after reset", {31'd0, dma_bank}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule